// File: doc/BRIEF.md
# Reorder Buffer Retirement Tracker

This block keeps the bookkeeping for micro-operations that are in flight between the rename stage and in-order retirement. It is a circular buffer of 192 entries. In each cycle the rename stage can claim up to four consecutive slots, which are taken in program order starting at the current tail. Every slot passes through a fixed sequence of states: it is first newly allocated, then sent to the scheduler, then completed. Execution units report completions out of order, and each report names the slot index.

In each cycle the tracker looks at the oldest slots. It retires a contiguous run of completed slots, up to four of them, beginning at the head. The run ends at the first slot that is not completed. The retiring slot indices appear on the outputs in the same cycle, and the slots are released at the next clock edge. A finished slot keeps its place until it retires. When the free space is too small for the current request, the tracker refuses it. A flush input empties the whole buffer in one cycle.

Top module: `rob_retire_tracker`

## Requirements
- R1: After reset, `allocBase` is 0, `retValid` is 0, `cmpError` is 0, and `allocReady` is 1 for any `allocCount` from 0 to 4.
- R2: A request of `allocCount` slots (1 to 4) is accepted in a cycle where `allocReady` is 1. It claims indices `allocBase` to `allocBase+allocCount-1` modulo 192, and `allocBase` moves forward by `allocCount` after the edge. A count above 4 is always refused.
- R3: When `allocCount` is larger than the number of free slots, `allocReady` is 0 and nothing is claimed, so `allocBase` stays unchanged. Occupancy never exceeds 192.
- R4: A completion report (`cmpValid[p]`, index in `cmpIdx` bits `p*8 +: 8`) takes effect only for a slot that has been sent to the scheduler. A report for a free slot, a newly allocated slot, or an already completed slot is ignored, and `cmpError` is 1 in the following cycle.
- R5: `retValid` is a mask of contiguous ones starting at bit 0. Lane k, meaning `retValid[k]` together with `retIdx` bits `k*8 +: 8`, names the slot at head+k. The run contains only completed slots, holds at most 4, and stops at the first slot that is not completed. The slots are freed at the next edge.
- R6: When the oldest slot is not completed, `retValid` is 0, even if younger slots are completed.
- R7: A completed slot stays in the buffer until every older slot has retired. It then retires in program order.
- R8: While `flush` is 1, `allocReady` and `retValid` are 0. After the edge, every slot is free and `allocBase` is 0, so a completion report for an earlier slot raises `cmpError`.
- R9: Slot indices wrap from 191 to 0 for both allocation and retirement, and program order is preserved across the wrap.
- R10: Once all 192 slots are occupied, a request for even one slot is refused until a slot retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the buffer and resets head and tail |
| allocCount | input | 3 | Number of slots requested this cycle (0 to 4) |
| allocReady | output | 1 | Request can be granted this cycle |
| allocBase | output | 8 | Index of the first slot a request would receive |
| issueValid | input | 1 | A slot is handed to the scheduler |
| issueIdx | input | 8 | Index of the slot handed to the scheduler |
| cmpValid | input | 2 | Completion report valid, one bit per report port |
| cmpIdx | input | 16 | Completed slot index per port, packed 8 bits each |
| retValid | output | 4 | Retire lane valid mask |
| retIdx | output | 32 | Retiring slot index per lane, packed 8 bits each |
| cmpError | output | 1 | A report in the previous cycle was invalid |

## Verification
Retirement is tested with completions arriving youngest first, so that the test can tell a tracker that retires any completed slot from one that waits for the oldest slot. A short burst in which one younger slot is left unfinished shows that the run stops at the gap. The buffer is filled to capacity, including requests slightly larger than the remaining space, which checks the boundary of the free-space comparison. All slots are then completed in reverse order and the oldest one last, which releases four-wide retirement bursts across the index wrap; a scoreboard in program order catches any reordering or skipped slot. Reports aimed at free, unsent, retired and flushed slots separate the lifecycle rule from plain index matching.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int ROB_DEPTH = 192;
  parameter int ALLOC_W   = 4;
  parameter int RET_W     = 4;
  parameter int CMP_PORTS = 2;

  localparam int IDX_W  = $clog2(ROB_DEPTH);
  localparam int OCC_W  = $clog2(ROB_DEPTH + 1);
  localparam int ACNT_W = $clog2(ALLOC_W + 1);
  localparam int RCNT_W = $clog2(RET_W + 1);

  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_NEW  = 2'd1,
    ENT_SENT = 2'd2,
    ENT_DONE = 2'd3
  } entState_t;

  // strobes from control to the state array
  typedef struct packed {
    logic              clear;
    logic              allocFire;
    logic [ACNT_W-1:0] allocNum;
    logic [IDX_W-1:0]  allocBase;
    logic [RCNT_W-1:0] retNum;
    logic [IDX_W-1:0]  headIdx;
  } robStrobe_t;

  function automatic logic [IDX_W-1:0] idxAdd(logic [IDX_W-1:0] base, int unsigned step);
    int unsigned s;
    s = 32'(base) + step;
    if (s >= ROB_DEPTH) s = s - ROB_DEPTH;
    return IDX_W'(s);
  endfunction

  function automatic int unsigned idxDist(logic [IDX_W-1:0] from, logic [IDX_W-1:0] to);
    if (to >= from) return 32'(to) - 32'(from);
    return 32'(to) + ROB_DEPTH - 32'(from);
  endfunction
endpackage

// File: rtl/rob_state_array.sv
module rob_state_array
  import rob_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  robStrobe_t                 strobe,
  input  logic                       issueValid,
  input  logic [IDX_W-1:0]           issueIdx,
  input  logic [CMP_PORTS-1:0]       cmpValid,
  input  logic [CMP_PORTS*IDX_W-1:0] cmpIdx,
  output logic [RET_W-1:0]           doneWin,
  output logic                       cmpError
);
  entState_t entState [ROB_DEPTH];
  entState_t entNext  [ROB_DEPTH];
  logic      errNow;

  always_comb begin
    logic        hitCmp;
    int unsigned aDist;
    int unsigned rDist;
    for (int i = 0; i < ROB_DEPTH; i++) begin
      hitCmp = 1'b0;
      for (int p = 0; p < CMP_PORTS; p++)
        if (cmpValid[p] && cmpIdx[p*IDX_W +: IDX_W] == IDX_W'(i)) hitCmp = 1'b1;
      aDist = idxDist(strobe.allocBase, IDX_W'(i));
      rDist = idxDist(strobe.headIdx, IDX_W'(i));
      entNext[i] = entState[i];
      if (strobe.clear)
        entNext[i] = ENT_FREE;
      else if (rDist < 32'(strobe.retNum))
        entNext[i] = ENT_FREE;
      else if (strobe.allocFire && aDist < 32'(strobe.allocNum))
        entNext[i] = ENT_NEW;
      else if (entState[i] == ENT_SENT && hitCmp)
        entNext[i] = ENT_DONE;
      else if (entState[i] == ENT_NEW && issueValid && issueIdx == IDX_W'(i))
        entNext[i] = ENT_SENT;
    end
  end

  always_comb begin
    logic [IDX_W-1:0] slotIdx;
    errNow = 1'b0;
    for (int p = 0; p < CMP_PORTS; p++) begin
      slotIdx = cmpIdx[p*IDX_W +: IDX_W];
      if (cmpValid[p] && !strobe.clear) begin
        if (32'(slotIdx) >= ROB_DEPTH) errNow = 1'b1;
        else if (entState[slotIdx] != ENT_SENT) errNow = 1'b1;
      end
    end
  end

  always_comb
    for (int k = 0; k < RET_W; k++)
      doneWin[k] = (entState[idxAdd(strobe.headIdx, k)] == ENT_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROB_DEPTH; i++) entState[i] <= ENT_FREE;
      cmpError <= 1'b0;
    end else begin
      for (int i = 0; i < ROB_DEPTH; i++) entState[i] <= entNext[i];
      cmpError <= errNow;
    end
  end
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic [ACNT_W-1:0]      allocCount,
  input  logic [RET_W-1:0]       doneWin,
  output robStrobe_t             strobe,
  output logic                   allocReady,
  output logic [IDX_W-1:0]       allocBase,
  output logic [RET_W-1:0]       retValid,
  output logic [RET_W*IDX_W-1:0] retIdx,
  output logic [OCC_W-1:0]       occupancy
);
  logic [IDX_W-1:0]  headPtr, tailPtr;
  logic [RCNT_W-1:0] retNum;
  logic              allocFire;

  always_comb begin
    logic run;
    run    = !flush;
    retNum = '0;
    for (int k = 0; k < RET_W; k++) begin
      run         = run & doneWin[k];
      retValid[k] = run;
      retNum      = retNum + RCNT_W'(run);
      retIdx[k*IDX_W +: IDX_W] = idxAdd(headPtr, k);
    end
  end

  assign allocReady = !flush && 32'(allocCount) <= ALLOC_W
                      && 32'(allocCount) + 32'(occupancy) <= ROB_DEPTH;
  assign allocFire  = allocReady && allocCount != '0;
  assign allocBase  = tailPtr;

  always_comb begin
    strobe.clear     = flush;
    strobe.allocFire = allocFire;
    strobe.allocNum  = allocCount;
    strobe.allocBase = tailPtr;
    strobe.retNum    = retNum;
    strobe.headIdx   = headPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      occupancy <= '0;
    end else if (flush) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      occupancy <= '0;
    end else begin
      headPtr <= idxAdd(headPtr, 32'(retNum));
      if (allocFire) tailPtr <= idxAdd(tailPtr, 32'(allocCount));
      occupancy <= occupancy + (allocFire ? OCC_W'(allocCount) : '0) - OCC_W'(retNum);
    end
  end
endmodule

// File: rtl/rob_retire_tracker.sv
module rob_retire_tracker
  import rob_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic [ACNT_W-1:0]          allocCount,
  output logic                       allocReady,
  output logic [IDX_W-1:0]           allocBase,
  input  logic                       issueValid,
  input  logic [IDX_W-1:0]           issueIdx,
  input  logic [CMP_PORTS-1:0]       cmpValid,
  input  logic [CMP_PORTS*IDX_W-1:0] cmpIdx,
  output logic [RET_W-1:0]           retValid,
  output logic [RET_W*IDX_W-1:0]     retIdx,
  output logic                       cmpError
);
  robStrobe_t       strobe;
  logic [RET_W-1:0] doneWin;
  logic [OCC_W-1:0] occupancy;

  rob_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .allocCount(allocCount),
    .doneWin(doneWin), .strobe(strobe), .allocReady(allocReady),
    .allocBase(allocBase), .retValid(retValid), .retIdx(retIdx),
    .occupancy(occupancy)
  );

  rob_state_array i_array (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueValid(issueValid),
    .issueIdx(issueIdx), .cmpValid(cmpValid), .cmpIdx(cmpIdx),
    .doneWin(doneWin), .cmpError(cmpError)
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker
  import rob_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic [ACNT_W-1:0] allocCount,
  input logic              allocReady,
  input logic [RET_W-1:0]  retValid,
  input logic [OCC_W-1:0]  occupancy
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    32'(occupancy) <= ROB_DEPTH);

  assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (allocReady && allocCount != '0 && retValid == '0)
      |=> 32'(occupancy) == 32'($past(occupancy)) + 32'($past(allocCount)));

  assert_ret_prefix_R5: assert property (@(posedge clk) disable iff (!rstN)
    (retValid & (retValid + RET_W'(1))) == '0);

  assert_ret_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(retValid) <= 32'(occupancy));

  assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (!allocReady && retValid == '0));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (occupancy == '0 && retValid == '0));
endmodule

bind rob_retire_tracker rob_checker i_rob_checker (
  .clk(clk), .rstN(rstN), .flush(flush), .allocCount(allocCount),
  .allocReady(allocReady), .retValid(retValid), .occupancy(occupancy)
);

// File: tb/test_rob_retire_tracker.sv
`timescale 1ns/1ps
module test_rob_retire_tracker;
  import rob_pkg::*;

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic                       flush = 1'b0;
  logic [ACNT_W-1:0]          allocCount = '0;
  logic                       allocReady;
  logic [IDX_W-1:0]           allocBase;
  logic                       issueValid = 1'b0;
  logic [IDX_W-1:0]           issueIdx = '0;
  logic [CMP_PORTS-1:0]       cmpValid = '0;
  logic [CMP_PORTS*IDX_W-1:0] cmpIdx = '0;
  logic [RET_W-1:0]           retValid;
  logic [RET_W*IDX_W-1:0]     retIdx;
  logic                       cmpError;

  int checks = 0;
  int failures = 0;
  int retTotal = 0;
  int expTail = 0;
  int expQ[$];
  int order[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rob_retire_tracker i_rob_retire_tracker (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the program-order scoreboard for each retiring lane
  always @(negedge clk) begin
    if (rstN) begin
      for (int k = 0; k < RET_W; k++) begin
        if (retValid[k]) begin
          int got;
          got = int'(retIdx[k*IDX_W +: IDX_W]);
          retTotal++;
          if (expQ.size() == 0) chk(1'b0, "R5", "retire with empty scoreboard", got, -1);
          else begin
            int e;
            e = expQ.pop_front();
            chk(got == e, "R7", "retired index in program order", got, e);
          end
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doAlloc(int n, bit expReady, string req);
    allocCount = ACNT_W'(n);
    #1;
    chk(allocReady == expReady, req, "allocReady", int'(allocReady), int'(expReady));
    chk(int'(allocBase) == expTail, req, "allocBase before", int'(allocBase), expTail);
    if (expReady)
      for (int i = 0; i < n; i++) expQ.push_back((expTail + i) % ROB_DEPTH);
    @(posedge clk);
    #1;
    allocCount = '0;
    if (expReady) expTail = (expTail + n) % ROB_DEPTH;
    chk(int'(allocBase) == expTail, req, "allocBase after", int'(allocBase), expTail);
  endtask

  task automatic doIssue(int idx);
    issueValid = 1'b1;
    issueIdx   = IDX_W'(idx);
    @(posedge clk);
    #1;
    issueValid = 1'b0;
  endtask

  task automatic doCmp(int a, bit va, int b, bit vb, bit expErr, string req);
    cmpValid = {vb, va};
    cmpIdx   = {IDX_W'(b), IDX_W'(a)};
    @(posedge clk);
    #1;
    cmpValid = '0;
    chk(cmpError == expErr, req, "cmpError", int'(cmpError), int'(expErr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int oldIdx;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk);
    #1;
    allocCount = 3'd4;
    #0.5;
    chk(allocReady == 1'b1, "R1", "allocReady after reset", int'(allocReady), 1);
    chk(allocBase == '0, "R1", "allocBase after reset", int'(allocBase), 0);
    chk(retValid == '0, "R1", "retValid after reset", int'(retValid), 0);
    chk(cmpError == 1'b0, "R1", "cmpError after reset", int'(cmpError), 0);
    allocCount = '0;
    #0.5;

    // R2 then R6/R7: younger finish first, oldest last
    doAlloc(4, 1'b1, "R2");
    for (int i = 0; i < 4; i++) doIssue(i);
    doCmp(2, 1'b1, 3, 1'b1, 1'b0, "R4");
    chk(retValid == '0, "R6", "young done, oldest pending", int'(retValid), 0);
    doCmp(1, 1'b1, 0, 1'b0, 1'b0, "R4");
    chk(retValid == '0, "R7", "completed slots held", int'(retValid), 0);
    doCmp(0, 1'b1, 0, 1'b0, 1'b0, "R4");
    chk(retValid == 4'b1111, "R5", "four-wide retire", int'(retValid), 15);
    idle(1);
    chk(retValid == '0, "R5", "slots freed after edge", int'(retValid), 0);

    // R4: lifecycle errors
    doCmp(10, 1'b1, 0, 1'b0, 1'b1, "R4");
    idle(1);
    chk(cmpError == 1'b0, "R4", "error is one cycle", int'(cmpError), 0);
    doAlloc(2, 1'b1, "R2");
    doCmp(4, 1'b1, 0, 1'b0, 1'b1, "R4");
    chk(retValid == '0, "R4", "unsent slot not completed", int'(retValid), 0);
    doIssue(4);
    doCmp(4, 1'b1, 0, 1'b0, 1'b0, "R4");
    chk(retValid == 4'b0001, "R5", "run stops at first pending", int'(retValid), 1);
    idle(1);
    doCmp(4, 1'b1, 0, 1'b0, 1'b1, "R4");
    doAlloc(5, 1'b0, "R2");

    // R3/R10: fill to capacity across the index wrap (R9)
    for (int i = 0; i < 47; i++) doAlloc(4, 1'b1, "R9");
    doAlloc(4, 1'b0, "R3");
    doAlloc(3, 1'b1, "R3");
    doAlloc(1, 1'b0, "R10");
    doIssue(5);
    doCmp(5, 1'b1, 0, 1'b0, 1'b0, "R4");
    idle(1);
    doAlloc(1, 1'b1, "R10");

    // R9: reverse completion, then bursts of four retire across the wrap
    order = expQ;
    foreach (order[i]) doIssue(order[i]);
    for (int i = order.size() - 1; i >= 1; i--) doCmp(order[i], 1'b1, 0, 1'b0, 1'b0, "R4");
    chk(retValid == '0, "R6", "full buffer, oldest pending", int'(retValid), 0);
    doCmp(order[0], 1'b1, 0, 1'b0, 1'b0, "R4");
    chk(retValid == 4'b1111, "R5", "burst starts four wide", int'(retValid), 15);
    idle(60);
    chk(expQ.size() == 0, "R9", "scoreboard drained", expQ.size(), 0);
    chk(retTotal == 198, "R9", "total retired", retTotal, 198);

    // R8: flush
    doAlloc(4, 1'b1, "R2");
    order = expQ;
    foreach (order[i]) doIssue(order[i]);
    doCmp(order[1], 1'b1, order[2], 1'b1, 1'b0, "R4");
    oldIdx = order[1];
    flush = 1'b1;
    allocCount = 3'd1;
    #1;
    chk(allocReady == 1'b0, "R8", "allocReady during flush", int'(allocReady), 0);
    chk(retValid == '0, "R8", "retValid during flush", int'(retValid), 0);
    @(posedge clk);
    #1;
    flush = 1'b0;
    allocCount = '0;
    expQ.delete();
    expTail = 0;
    chk(allocBase == '0, "R8", "allocBase after flush", int'(allocBase), 0);
    doCmp(oldIdx, 1'b1, 0, 1'b0, 1'b1, "R8");
    doAlloc(4, 1'b1, "R8");
    idle(2);
    chk(retValid == '0, "R8", "fresh slots not retiring", int'(retValid), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule